// File: doc/BRIEF.md
# Page Table Walker (single level, direct index)

This block turns a virtual page number into a physical page number by reading one entry from a flat page table in memory. The table holds one 32-bit entry for every virtual page. It is indexed directly by the page number, so no tag is stored or compared. A control port loads the table's base address. System software reloads it whenever the running process changes, because each process has its own table.

A translation request carries a 20-bit virtual page number, which is the upper part of a 32-bit virtual address whose 12-bit page offset is not touched here. The walker adds four times the page number to the base and issues a single word read on a request/response memory port. It then waits as long as the memory needs. When the entry arrives, the walker checks the entry's valid flag. A set flag returns the 18-bit physical page number, which gives a 30-bit physical address once the offset is appended. A clear flag returns a page-fault indication. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `resp_valid` and `mem_rd_req` are 0.
- R2: The read address is the base register with its two low bits cleared, plus the virtual page number times 4, modulo 2^32. It is therefore always word aligned.
- R3: Each accepted request causes exactly one read. `mem_rd_req` is high for exactly the one cycle that follows the accepting clock edge.
- R4: `req_ready` is 1 only when no walk is in progress. It stays 0 from the accepting edge until the response cycle is over.
- R5: The memory may answer after any number of cycles. `resp_valid` rises in the cycle after `mem_rd_rvalid` is seen while a read is outstanding.
- R6: If entry bit 31 (valid) is 1, the response has `resp_fault`=0, `resp_ppn`=entry bits 17:0 and `resp_dirty`=entry bit 30.
- R7: If entry bit 31 is 0, the response has `resp_fault`=1, `resp_ppn`=0 and `resp_dirty`=0.
- R8: Entry bits 29:18 have no effect on any response field.
- R9: A base write is used only by requests accepted after the write's clock edge. A write in the same cycle as an accept, or during a walk, leaves the current walk's address unchanged.
- R10: `mem_rd_rvalid` asserted while no read is outstanding produces no response and does not change `req_ready`.
- R11: `resp_valid` is a one-cycle pulse, and `req_ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the page-table base register |
| cfg_base | input | 32 | New page-table base byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vpn | input | 20 | Virtual page number to translate |
| mem_rd_req | output | 1 | One-cycle word read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry read |
| mem_rd_rvalid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Page table entry |
| resp_valid | output | 1 | Translation result pulse |
| resp_ppn | output | 18 | Physical page number (0 on fault) |
| resp_fault | output | 1 | Entry was not valid: page fault |
| resp_dirty | output | 1 | Entry dirty flag (0 on fault) |

## Verification
The bench sweeps many page numbers against several base values. These include a misaligned base, which a design without the low-bit clearing would turn into an unaligned read, and a base near the top of the address space, where a design with a narrow adder would produce a wrong wrapped address. Memory latency varies from zero to three extra cycles, so a walker that expects a fixed latency would miss the data or respond early. The entry contents are generated so that valid, dirty and reserved bits all change. Reserved bits leaking into the page number, or a stale page number on a fault, would then show up. Base writes arrive in the same cycle as an accept and in the middle of a walk, which exposes a walker that reads the base live instead of latching it. A stray read-data strobe while idle catches a walker that answers without having asked.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } ptw_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
   parameter int unsigned MADDR_W   = 32,
   parameter int unsigned PTE_BYTES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [MADDR_W-1:0] wr_val,
   output logic [MADDR_W-1:0] base
);
   localparam int unsigned ALIGN_BITS = $clog2(PTE_BYTES);

   logic [MADDR_W-1:0] base_q;
   logic [MADDR_W-1:0] aligned_val;

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign aligned_val = wr_val;
      end else begin : g_align
         localparam logic [MADDR_W-1:0] LOW_MASK = MADDR_W'(PTE_BYTES - 1);
         assign aligned_val = wr_val & ~LOW_MASK;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_en) begin
         base_q <= aligned_val;
      end
   end

   assign base = base_q;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned MADDR_W   = 32,
   parameter int unsigned PTE_BYTES = 4
) (
   input  logic [MADDR_W-1:0] base,
   input  logic [VPN_W-1:0]   vpn,
   output logic [MADDR_W-1:0] entry_addr
);
   localparam int unsigned IDX_SHIFT = $clog2(PTE_BYTES);

   logic [MADDR_W-1:0] vpn_ext;
   logic [MADDR_W-1:0] byte_off;

   assign vpn_ext = MADDR_W'(vpn);

   generate
      if (IDX_SHIFT == 0) begin : g_byte_entries
         assign byte_off = vpn_ext;
      end else begin : g_wide_entries
         assign byte_off = vpn_ext << IDX_SHIFT;
      end
   endgenerate

   assign entry_addr = base + byte_off;
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned PPN_W     = 18,
   parameter int unsigned VALID_BIT = 31,
   parameter int unsigned DIRTY_BIT = 30,
   parameter bit          HAS_DIRTY = 1'b1
) (
   input  logic [PTE_W-1:0] entry,
   output logic             ent_valid,
   output logic             ent_dirty,
   output logic [PPN_W-1:0] ent_ppn
);
   logic unused_entry_bits;

   assign ent_valid = entry[VALID_BIT];
   assign ent_ppn   = entry[PPN_W-1:0];

   generate
      if (HAS_DIRTY) begin : g_dirty
         assign ent_dirty = entry[DIRTY_BIT];
      end else begin : g_no_dirty
         assign ent_dirty = 1'b0;
      end
   endgenerate

   // Reserved bits are deliberately not consumed.
   assign unused_entry_bits = ^entry;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
   import ptw_pkg::*;
#(
   parameter int unsigned MADDR_W = 32,
   parameter int unsigned PPN_W   = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [MADDR_W-1:0] next_addr,
   output logic               rd_req,
   output logic [MADDR_W-1:0] rd_addr,
   input  logic               rd_rvalid,
   input  logic               ent_valid,
   input  logic               ent_dirty,
   input  logic [PPN_W-1:0]   ent_ppn,
   output logic               resp_valid,
   output logic [PPN_W-1:0]   resp_ppn,
   output logic               resp_fault,
   output logic               resp_dirty
);
   ptw_state_e         state_q, state_d;
   logic [MADDR_W-1:0] addr_q;
   logic [PPN_W-1:0]   ppn_q;
   logic               fault_q;
   logic               dirty_q;
   logic               accept;
   logic               take_data;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign take_data = (state_q == ST_WAIT) && rd_rvalid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept)    state_d = ST_ISSUE;
         ST_ISSUE:                state_d = ST_WAIT;
         ST_WAIT:  if (take_data) state_d = ST_RESP;
         ST_RESP:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   // Address is captured at accept, so later base writes cannot move it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (accept) begin
         addr_q <= next_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ppn_q   <= '0;
         fault_q <= 1'b0;
         dirty_q <= 1'b0;
      end else if (take_data) begin
         fault_q <= !ent_valid;
         ppn_q   <= ent_valid ? ent_ppn : '0;
         dirty_q <= ent_valid && ent_dirty;
      end
   end

   assign rd_req     = (state_q == ST_ISSUE);
   assign rd_addr    = addr_q;
   assign resp_valid = (state_q == ST_RESP);
   assign resp_ppn   = ppn_q;
   assign resp_fault = fault_q;
   assign resp_dirty = dirty_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned PPN_W     = 18,
   parameter int unsigned MADDR_W   = 32,
   parameter int unsigned PTE_BYTES = 4,
   parameter int unsigned VALID_BIT = 31,
   parameter int unsigned DIRTY_BIT = 30,
   parameter bit          HAS_DIRTY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [MADDR_W-1:0] cfg_base,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VPN_W-1:0]   req_vpn,
   output logic               mem_rd_req,
   output logic [MADDR_W-1:0] mem_rd_addr,
   input  logic               mem_rd_rvalid,
   input  logic [PTE_BYTES*8-1:0] mem_rd_data,
   output logic               resp_valid,
   output logic [PPN_W-1:0]   resp_ppn,
   output logic               resp_fault,
   output logic               resp_dirty
);
   localparam int unsigned PTE_W     = PTE_BYTES * 8;
   localparam int unsigned IDX_SHIFT = $clog2(PTE_BYTES);

   generate
      if (!is_pow2(PTE_BYTES)) begin : g_bad_pte_bytes
         $error("PTE_BYTES must be a power of two");
      end
      if (VPN_W + IDX_SHIFT > MADDR_W) begin : g_bad_addr_w
         $error("table does not fit in the memory address space");
      end
      if (VALID_BIT >= PTE_W || DIRTY_BIT >= PTE_W) begin : g_bad_flag_pos
         $error("flag bit outside the entry");
      end
      if (VALID_BIT == DIRTY_BIT) begin : g_flag_clash
         $error("valid and dirty flags share a bit");
      end
      if (PPN_W > VALID_BIT || (HAS_DIRTY && PPN_W > DIRTY_BIT)) begin : g_ppn_overlap
         $error("page number field overlaps a flag");
      end
   endgenerate

   logic [MADDR_W-1:0] base;
   logic [MADDR_W-1:0] next_addr;
   logic               ent_valid;
   logic               ent_dirty;
   logic [PPN_W-1:0]   ent_ppn;

   ptw_base_reg #(
      .MADDR_W   (MADDR_W),
      .PTE_BYTES (PTE_BYTES)
   ) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_val (cfg_base),
      .base   (base)
   );

   ptw_addr_gen #(
      .VPN_W     (VPN_W),
      .MADDR_W   (MADDR_W),
      .PTE_BYTES (PTE_BYTES)
   ) u_addr (
      .base       (base),
      .vpn        (req_vpn),
      .entry_addr (next_addr)
   );

   ptw_entry_decode #(
      .PTE_W     (PTE_W),
      .PPN_W     (PPN_W),
      .VALID_BIT (VALID_BIT),
      .DIRTY_BIT (DIRTY_BIT),
      .HAS_DIRTY (HAS_DIRTY)
   ) u_dec (
      .entry     (mem_rd_data),
      .ent_valid (ent_valid),
      .ent_dirty (ent_dirty),
      .ent_ppn   (ent_ppn)
   );

   ptw_ctrl #(
      .MADDR_W (MADDR_W),
      .PPN_W   (PPN_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .next_addr  (next_addr),
      .rd_req     (mem_rd_req),
      .rd_addr    (mem_rd_addr),
      .rd_rvalid  (mem_rd_rvalid),
      .ent_valid  (ent_valid),
      .ent_dirty  (ent_dirty),
      .ent_ppn    (ent_ppn),
      .resp_valid (resp_valid),
      .resp_ppn   (resp_ppn),
      .resp_fault (resp_fault),
      .resp_dirty (resp_dirty)
   );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
   parameter int unsigned MADDR_W   = 32,
   parameter int unsigned PPN_W     = 18,
   parameter int unsigned PTE_BYTES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               mem_rd_req,
   input logic [MADDR_W-1:0] mem_rd_addr,
   input logic               mem_rd_rvalid,
   input logic               resp_valid,
   input logic [PPN_W-1:0]   resp_ppn,
   input logic               resp_fault,
   input logic               resp_dirty
);
   localparam logic [MADDR_W-1:0] LOW_MASK = MADDR_W'(PTE_BYTES - 1);

   logic outstanding;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
      end else if (mem_rd_req) begin
         outstanding <= 1'b1;
      end else if (mem_rd_rvalid) begin
         outstanding <= 1'b0;
      end
   end

   p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> ((mem_rd_addr & LOW_MASK) == '0));

   p_read_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> mem_rd_req);

   p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || outstanding || resp_valid) |-> !req_ready);

   p_resp_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding && mem_rd_rvalid) |=> resp_valid);

   p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault) |-> (resp_ppn == '0 && !resp_dirty));

   p_no_stray_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(outstanding && mem_rd_rvalid));

   p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> (!resp_valid && req_ready));
endmodule

bind pt_walker ptw_checker #(
   .MADDR_W   (MADDR_W),
   .PPN_W     (PPN_W),
   .PTE_BYTES (PTE_BYTES)
) u_ptw_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_rd_req    (mem_rd_req),
   .mem_rd_addr   (mem_rd_addr),
   .mem_rd_rvalid (mem_rd_rvalid),
   .resp_valid    (resp_valid),
   .resp_ppn      (resp_ppn),
   .resp_fault    (resp_fault),
   .resp_dirty    (resp_dirty)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_vpn = '0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_rvalid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        resp_valid;
   logic [17:0] resp_ppn;
   logic        resp_fault;
   logic        resp_dirty;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] cur_base = '0;

   always #2 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_base(cfg_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_data(mem_rd_data),
      .resp_valid(resp_valid), .resp_ppn(resp_ppn),
      .resp_fault(resp_fault), .resp_dirty(resp_dirty)
   );

   // Table content as a function of entry address: valid, dirty, reserved and
   // page number all vary.
   function automatic logic [31:0] tbl(input logic [31:0] a);
      logic v;
      v = !(a[2] && a[3]);
      return {v, a[5], a[13:2] ^ 12'h3C5, a[19:2] ^ 18'h2A5A5};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // mode 0: no base write, 1: write with the request, 2: write mid-walk
   task automatic do_walk(input logic [19:0] vpn, input int lat, input int mode,
                          input logic [31:0] wval);
      logic [31:0] ea;
      logic [31:0] e;
      ea = (cur_base & 32'hFFFF_FFFC) + {10'b0, vpn, 2'b00};
      e  = tbl(ea);
      chk(req_ready === 1'b1, "R4 ready idle", {31'b0, req_ready}, 1);
      req_valid = 1'b1;
      req_vpn   = vpn;
      if (mode == 1) begin cfg_we = 1'b1; cfg_base = wval; end
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we    = 1'b0;
      chk(mem_rd_req === 1'b1, "R3 strobe", {31'b0, mem_rd_req}, 1);
      chk(mem_rd_addr === ea, "R2 addr", mem_rd_addr, ea);
      if (mode == 1) chk(mem_rd_addr === ea, "R9 same-cycle write", mem_rd_addr, ea);
      chk(req_ready === 1'b0, "R4 busy", {31'b0, req_ready}, 0);
      if (mode == 2) begin cfg_we = 1'b1; cfg_base = wval; end
      @(negedge clk);
      cfg_we = 1'b0;
      chk(mem_rd_req === 1'b0, "R3 single", {31'b0, mem_rd_req}, 0);
      for (int i = 0; i < lat; i++) begin
         chk(resp_valid === 1'b0 && req_ready === 1'b0, "R5 wait",
             {30'b0, resp_valid, req_ready}, 0);
         @(negedge clk);
      end
      mem_rd_rvalid = 1'b1;
      mem_rd_data   = e;
      @(negedge clk);
      mem_rd_rvalid = 1'b0;
      mem_rd_data   = 32'hDEAD_BEEF;
      chk(resp_valid === 1'b1, "R5 resp", {31'b0, resp_valid}, 1);
      if (e[31]) begin
         chk(resp_fault === 1'b0, "R6 fault", {31'b0, resp_fault}, 0);
         chk(resp_ppn === e[17:0], "R6 ppn", {14'b0, resp_ppn}, {14'b0, e[17:0]});
         chk(resp_dirty === e[30], "R6 dirty", {31'b0, resp_dirty}, {31'b0, e[30]});
         chk(resp_ppn === e[17:0], "R8 reserved", {14'b0, resp_ppn}, {14'b0, e[17:0]});
      end else begin
         chk(resp_fault === 1'b1, "R7 fault", {31'b0, resp_fault}, 1);
         chk(resp_ppn === 18'd0, "R7 ppn", {14'b0, resp_ppn}, 0);
         chk(resp_dirty === 1'b0, "R7 dirty", {31'b0, resp_dirty}, 0);
      end
      @(negedge clk);
      chk(resp_valid === 1'b0 && req_ready === 1'b1, "R11 pulse",
          {30'b0, resp_valid, req_ready}, 1);
      if (mode != 0) cur_base = wval;
   endtask

   task automatic set_base(input logic [31:0] b);
      cfg_we = 1'b1; cfg_base = b;
      @(negedge clk);
      cfg_we = 1'b0;
      cur_base = b;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      logic [31:0] bases [4];
      bases[0] = 32'h0000_0000;
      bases[1] = 32'h0001_2003;
      bases[2] = 32'hFFFF_F000;
      bases[3] = 32'h4000_0000;
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd_req === 1'b0,
          "R1 in reset", {29'b0, req_ready, resp_valid, mem_rd_req}, 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd_req === 1'b0,
          "R1 after reset", {29'b0, req_ready, resp_valid, mem_rd_req}, 4);

      for (int b = 0; b < 4; b++) begin
         set_base(bases[b]);
         for (int v = 0; v < 48; v++) do_walk(20'(v), v % 4, 0, 0);
         do_walk(20'hFFFFF, 2, 0, 0);
         do_walk(20'h80000, 1, 0, 0);
         do_walk(20'h7FFFF, 0, 0, 0);
      end

      // R9: write during a walk, then the next walk uses it.
      set_base(32'h0000_8000);
      do_walk(20'h00013, 3, 2, 32'h0010_0000);
      do_walk(20'h00013, 1, 0, 0);
      // R9: write in the same cycle as the accept.
      do_walk(20'h00021, 2, 1, 32'h0020_0004);
      do_walk(20'h00021, 0, 0, 0);

      // R10: stray data strobe while idle.
      mem_rd_rvalid = 1'b1;
      mem_rd_data   = 32'h8000_1234;
      @(negedge clk);
      mem_rd_rvalid = 1'b0;
      chk(resp_valid === 1'b0, "R10 no resp", {31'b0, resp_valid}, 0);
      chk(req_ready === 1'b1, "R10 ready", {31'b0, req_ready}, 1);
      @(negedge clk);
      chk(resp_valid === 1'b0, "R10 still quiet", {31'b0, resp_valid}, 0);
      do_walk(20'h00005, 2, 0, 0);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end
endmodule